// File: doc/BRIEF.md
# Phase-Cut Gate Pulse Generator

This block produces the single gate-enable level that drives a pair of back-to-back transistors switching an AC load. Each half cycle begins with a one-clock zero-crossing strobe. The block then opens the conduction window in one of two ways. In trailing-edge operation the window starts at the strobe and closes after an on-time. In leading-edge operation the window stays shut for an off-time and then stays open until the next strobe. An 8-bit dim code selects the time in steps of 25 µs. A parameterised divider turns the system clock into a 25 µs tick, and every accepted strobe realigns that tick.

After reset the block watches a strap input for a fixed window of ticks. At the end of the window it latches the strap level as the edge mode, and the mode holds until the next reset. The gate stays low until the mode has been latched. A frequency select stretches every time by 6/5 for 50 Hz mains. A force-full input holds the gate on continuously. A fault input blanks the gate for the rest of the current half cycle. All inputs are plain level or strobe control pins with no stream data, so there is no valid/ready handshake and no back-pressure anywhere. The block samples the dim code and the frequency select once per half cycle, at the strobe.

Top module: `phase_cut_gate`

## Requirements
- R1: After reset the gate is low. The mode strap is sampled once, at the end of MODE_WIN_TICKS ticks: 0 selects trailing edge and 1 selects leading edge. Later changes of the strap have no effect until the next reset, and zero-crossing strobes arriving before the mode is latched are ignored.
- R2: In trailing-edge mode the gate goes high on the clock edge that samples the strobe. It stays high for exactly the on-time, measured in ticks of TICK_DIV clocks, and then stays low until the next strobe.
- R3: In leading-edge mode the gate goes low on the clock edge that samples the strobe. It goes high after exactly the off-time and stays high until the next strobe.
- R4: At 60 Hz (freq_sel=0) the on-time is dim_code+25 ticks and the off-time is 307-dim_code ticks. For example, code 216 gives 241 ticks on and 91 ticks off.
- R5: At 50 Hz (freq_sel=1) each 60 Hz time t in ticks becomes floor(6*t/5) ticks.
- R6: While force_full is 1 and the mode is latched, the gate is high continuously, with or without strobes, unless R8 blanks it.
- R7: A dim code of 0, sampled at the strobe, keeps the gate low for the whole half cycle in either mode.
- R8: A cycle with fault_block=1 drives the gate low from the next clock edge until the next strobe, and this overrides R6. A strobe then restores normal operation.
- R9: A strobe that arrives before the current window has finished restarts the timing from that strobe.
- R10: dim_code and freq_sel are captured at the strobe. Changes made during the half cycle do not alter its width.
- R11: Each accepted strobe resets the tick divider, so times are exact multiples of TICK_DIV clocks from the strobe edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| zc_pulse | input | 1 | One-clock zero-crossing strobe |
| mode_pin | input | 1 | Edge-mode strap (0 trailing, 1 leading), latched once |
| dim_code | input | 8 | Dim level; 0 means off |
| force_full | input | 1 | Hold gate on for the full cycle |
| fault_block | input | 1 | Blank gate for the rest of the half cycle |
| freq_sel | input | 1 | 0 for 60 Hz timing, 1 for 50 Hz (times x6/5) |
| gate_en | output | 1 | Gate enable for the transistor pair |

## Verification
The bench measures window lengths to the exact clock at both ends of the code range and in both frequency settings. A design that ignored the divider realignment, or was off by one tick, would miss those counts by a few clocks. A strobe is sent halfway through a window, and the dim code is changed mid-cycle. A timer that did not restart, or a width that was not captured at the strobe, would then produce a shortened window or the new width. The strap is toggled after it has been latched, and the gate is still expected to follow the original mode. The bench also checks that a fault during force-full still darkens the gate until the next strobe, which a design that gave force-full priority would fail.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

  typedef enum logic {
    EDGE_TRAIL = 1'b0,
    EDGE_LEAD  = 1'b1
  } edge_mode_e;

  localparam int unsigned TW = 10;
  typedef logic [TW-1:0] ticks_t;

  // 50 Hz stretch: floor(t * 6 / 5)
  function automatic ticks_t stretch_50(input ticks_t t);
    logic [TW+2:0] prod;
    prod = ({3'b000, t} << 2) + ({3'b000, t} << 1);
    return ticks_t'(prod / (TW+3)'(5));
  endfunction

endpackage

// File: rtl/pcg_tick_div.sv
module pcg_tick_div #(
  parameter int unsigned DIV = 6250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic realign,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV <= 1) begin : g_pass
      assign tick = ~realign;
    end else begin : g_count
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (realign)        cnt_q <= '0;
        else if (cnt_q == LAST)  cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
      end

      assign tick = ~realign & (cnt_q == LAST);

      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R11
      AST_TICK_REALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        realign |=> !tick); // R11
    end
  endgenerate
endmodule

// File: rtl/pcg_mode_latch.sv
module pcg_mode_latch
  import pcg_pkg::*;
#(
  parameter int unsigned WIN = 2400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       mode_pin,
  output edge_mode_e mode,
  output logic       valid
);
  localparam int unsigned CW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIN - 1);

  logic [CW-1:0] win_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q <= '0;
      valid <= 1'b0;
      mode  <= EDGE_TRAIL;
    end else if (!valid && tick) begin
      if (win_q == LAST) begin
        valid <= 1'b1;
        mode  <= edge_mode_e'(mode_pin);
      end else begin
        win_q <= win_q + 1'b1;
      end
    end
  end

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> valid && $stable(mode)); // R1
  AST_MODE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !valid && !tick |=> !valid); // R1
endmodule

// File: rtl/pcg_width_map.sv
module pcg_width_map
  import pcg_pkg::*;
#(
  parameter int unsigned ON_BASE   = 25,
  parameter int unsigned HALF_SPAN = 332
) (
  input  logic [7:0] code,
  input  logic       slow_mains,
  output ticks_t     on_ticks,
  output ticks_t     off_ticks,
  output logic       is_off
);
  ticks_t on_60, off_60;

  always_comb begin
    on_60     = ticks_t'(code) + ticks_t'(ON_BASE);
    off_60    = ticks_t'(HALF_SPAN) - on_60;
    on_ticks  = slow_mains ? stretch_50(on_60)  : on_60;
    off_ticks = slow_mains ? stretch_50(off_60) : off_60;
    is_off    = (code == 8'd0);
  end
endmodule

// File: rtl/pcg_phase_seq.sv
module pcg_phase_seq
  import pcg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       zc_pulse,
  input  logic       mode_valid,
  input  edge_mode_e mode,
  input  logic       code_zero,
  input  ticks_t     on_ticks,
  input  ticks_t     off_ticks,
  input  logic       force_full,
  input  logic       fault_block,
  output logic       gate
);
  logic   armed_q, zero_q, blk_q, gate_q;
  ticks_t width_q, elap_q;

  logic   zc_acc, armed_d, zero_d, blk_d, reached, gate_d;
  ticks_t width_d, elap_d;

  always_comb begin
    zc_acc  = zc_pulse & mode_valid;
    armed_d = armed_q | zc_acc;
    zero_d  = zc_acc ? code_zero : zero_q;
    width_d = zc_acc ? ((mode == EDGE_TRAIL) ? on_ticks : off_ticks) : width_q;
    if (zc_acc)                   elap_d = '0;
    else if (tick && elap_q != '1) elap_d = elap_q + 1'b1;
    else                          elap_d = elap_q;
    blk_d   = fault_block | (blk_q & ~zc_acc);
    reached = (elap_d >= width_d);

    if (!mode_valid)              gate_d = 1'b0;
    else if (blk_d)               gate_d = 1'b0;
    else if (force_full)          gate_d = 1'b1;
    else if (!armed_d || zero_d)  gate_d = 1'b0;
    else if (mode == EDGE_TRAIL)  gate_d = ~reached;
    else                          gate_d = reached;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      zero_q  <= 1'b1;
      blk_q   <= 1'b0;
      width_q <= '0;
      elap_q  <= '0;
      gate_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      zero_q  <= zero_d;
      blk_q   <= blk_d;
      width_q <= width_d;
      elap_q  <= elap_d;
      gate_q  <= gate_d;
    end
  end

  assign gate = gate_q;

  AST_PREMODE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_valid |-> !gate); // R1
  AST_TRAIL_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid && mode == EDGE_TRAIL && zc_pulse && !fault_block && !code_zero
    |=> gate); // R2
  AST_LEAD_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid && mode == EDGE_LEAD && zc_pulse && !force_full
    |=> !gate); // R3
  AST_FORCE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid && force_full && !fault_block && (!blk_q || zc_pulse)
    |=> gate); // R6
  AST_ZERO_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && zero_q && !zc_pulse && !force_full |=> !gate); // R7
  AST_FAULT_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    fault_block |=> !gate); // R8
  AST_BLOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    blk_q && !zc_pulse |=> !gate); // R8
endmodule

// File: rtl/phase_cut_gate.sv
module phase_cut_gate
  import pcg_pkg::*;
#(
  parameter int unsigned TICK_DIV        = 6250,
  parameter int unsigned MODE_WIN_TICKS  = 2400,
  parameter int unsigned ON_BASE_TICKS   = 25,
  parameter int unsigned HALF_SPAN_TICKS = 332
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       zc_pulse,
  input  logic       mode_pin,
  input  logic [7:0] dim_code,
  input  logic       force_full,
  input  logic       fault_block,
  input  logic       freq_sel,
  output logic       gate_en
);
  logic       tick, mode_valid, code_zero;
  edge_mode_e mode;
  ticks_t     on_ticks, off_ticks;
  logic       realign;

  assign realign = zc_pulse & mode_valid;

  pcg_tick_div #(.DIV(TICK_DIV)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .realign (realign),
    .tick    (tick)
  );

  pcg_mode_latch #(.WIN(MODE_WIN_TICKS)) u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .mode_pin (mode_pin),
    .mode     (mode),
    .valid    (mode_valid)
  );

  pcg_width_map #(.ON_BASE(ON_BASE_TICKS), .HALF_SPAN(HALF_SPAN_TICKS)) u_map (
    .code       (dim_code),
    .slow_mains (freq_sel),
    .on_ticks   (on_ticks),
    .off_ticks  (off_ticks),
    .is_off     (code_zero)
  );

  pcg_phase_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .zc_pulse    (zc_pulse),
    .mode_valid  (mode_valid),
    .mode        (mode),
    .code_zero   (code_zero),
    .on_ticks    (on_ticks),
    .off_ticks   (off_ticks),
    .force_full  (force_full),
    .fault_block (fault_block),
    .gate        (gate_en)
  );
endmodule

// File: tb/tb_phase_cut_gate.sv
`timescale 1ns/1ps
module tb_phase_cut_gate;
  localparam int DIV = 4;
  localparam int WIN = 8;

  logic clk = 1'b0;
  logic rst_n, zc_pulse, mode_pin, force_full, fault_block, freq_sel;
  logic [7:0] dim_code;
  logic gate_en;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  phase_cut_gate #(.TICK_DIV(DIV), .MODE_WIN_TICKS(WIN)) dut (
    .clk(clk), .rst_n(rst_n), .zc_pulse(zc_pulse), .mode_pin(mode_pin),
    .dim_code(dim_code), .force_full(force_full), .fault_block(fault_block),
    .freq_sel(freq_sel), .gate_en(gate_en)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int trail_cycles(input int code, input bit slow);
    int t = code + 25;
    if (slow) t = (t * 6) / 5;
    return t * DIV;
  endfunction

  function automatic int lead_cycles(input int code, input bit slow);
    int t = 307 - code;
    if (slow) t = (t * 6) / 5;
    return t * DIV;
  endfunction

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_zc();
    @(negedge clk); zc_pulse = 1'b1;
    @(negedge clk); zc_pulse = 1'b0;
  endtask

  task automatic count_level(input logic lvl, input int limit, output int n);
    n = 0;
    while (gate_en == lvl && n < limit) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_reset(input logic m);
    rst_n = 1'b0; zc_pulse = 1'b0; mode_pin = m; force_full = 1'b0;
    fault_block = 1'b0; freq_sel = 1'b0; dim_code = 8'd216;
    wait_n(4);
    rst_n = 1'b1;
    wait_n(2);
    check("R1 gate low after reset", int'(gate_en), 0);
    pulse_zc();  // ignored, mode not latched yet
    wait_n(WIN * DIV + 6);
    check("R1 early strobe ignored", int'(gate_en), 0);
    mode_pin = ~m;  // must have no effect from here on
  endtask

  task automatic t_mode_window();
    int n;
    rst_n = 1'b0; zc_pulse = 1'b0; mode_pin = 1'b0; fault_block = 1'b0;
    freq_sel = 1'b0; dim_code = 8'd216; force_full = 1'b1;
    wait_n(4);
    rst_n = 1'b1;
    wait_n(WIN * DIV / 2);
    check("R1 gate low inside mode window", int'(gate_en), 0);
    wait_n(WIN * DIV);
    count_level(1'b1, 1000, n);
    check("R6 force_full holds gate on", n, 1000);
    fault_block = 1'b1; @(negedge clk); fault_block = 1'b0;
    count_level(1'b0, 300, n);
    check("R8 fault overrides force_full", n, 300);
    force_full = 1'b0;
  endtask

  task automatic t_trail_widths();
    int n;
    do_reset(1'b0);
    dim_code = 8'd216; pulse_zc(); count_level(1'b1, 3000, n);
    check("R2 R4 trailing code 216", n, trail_cycles(216, 0));
    dim_code = 8'd255; pulse_zc(); count_level(1'b1, 3000, n);
    check("R4 trailing code 255", n, trail_cycles(255, 0));
    dim_code = 8'd1; pulse_zc(); count_level(1'b1, 3000, n);
    check("R4 trailing code 1", n, trail_cycles(1, 0));
    freq_sel = 1'b1; dim_code = 8'd216; pulse_zc(); count_level(1'b1, 3000, n);
    check("R5 trailing 50 Hz code 216", n, trail_cycles(216, 1));
    freq_sel = 1'b0;
    count_level(1'b0, 200, n);
    check("R2 gate stays low after on-time", n, 200);
  endtask

  task automatic t_zero_code();
    int n;
    dim_code = 8'd0; pulse_zc(); count_level(1'b0, 1500, n);
    check("R7 zero code keeps gate low", n, 1500);
  endtask

  task automatic t_fault();
    int n;
    dim_code = 8'd216; pulse_zc(); wait_n(100);
    check("R8 gate high before fault", int'(gate_en), 1);
    fault_block = 1'b1; @(negedge clk); fault_block = 1'b0;
    count_level(1'b0, 1200, n);
    check("R8 gate blanked rest of half cycle", n, 1200);
    pulse_zc(); count_level(1'b1, 3000, n);
    check("R8 strobe restores gate", n, trail_cycles(216, 0));
  endtask

  task automatic t_early_strobe();
    int n;
    dim_code = 8'd216; pulse_zc(); wait_n(401);
    pulse_zc(); count_level(1'b1, 3000, n);
    check("R9 R11 early strobe restarts timer", n, trail_cycles(216, 0));
  endtask

  task automatic t_capture();
    int n;
    dim_code = 8'd216; pulse_zc();
    dim_code = 8'd100; freq_sel = 1'b1;
    count_level(1'b1, 3000, n);
    check("R10 width captured at strobe", n, trail_cycles(216, 0));
    freq_sel = 1'b0;
    pulse_zc(); count_level(1'b1, 3000, n);
    check("R10 new code on next strobe", n, trail_cycles(100, 0));
  endtask

  task automatic t_leading();
    int n;
    do_reset(1'b1);
    dim_code = 8'd216; pulse_zc(); count_level(1'b0, 3000, n);
    check("R3 R4 leading off-time code 216", n, lead_cycles(216, 0));
    count_level(1'b1, 1500, n);
    check("R3 leading stays on to next strobe", n, 1500);
    dim_code = 8'd255; pulse_zc(); count_level(1'b0, 3000, n);
    check("R4 leading off-time code 255", n, lead_cycles(255, 0));
    freq_sel = 1'b1; dim_code = 8'd216; pulse_zc(); count_level(1'b0, 3000, n);
    check("R5 leading 50 Hz code 216", n, lead_cycles(216, 1));
    freq_sel = 1'b0;
    dim_code = 8'd0; pulse_zc(); count_level(1'b0, 1500, n);
    check("R7 zero code in leading mode", n, 1500);
  endtask

  initial begin
    rst_n = 1'b0; zc_pulse = 1'b0; mode_pin = 1'b0; force_full = 1'b0;
    fault_block = 1'b0; freq_sel = 1'b0; dim_code = 8'd0;
    t_mode_window();
    t_trail_widths();
    t_zero_code();
    t_fault();
    t_early_strobe();
    t_capture();
    t_leading();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule